// File: doc/BRIEF.md
# Two-Column Weighted Bit Counter

This block adds up ten bits from two adjacent columns of a partial-product matrix. Five bits have weight one and five have weight two. It returns the total as a 4-bit binary word. It is purely combinational, and it is meant to be placed many times in a row to compress a tall matrix of bits into a shorter one.

The block does not use a 1024-entry lookup and does not use a ripple of adders. Each column is first collapsed into six mutually exclusive "count" lines, one for each possible number of set bits. A small intersection matrix then sets each output bit from the pair of active lines, one from each column. The least significant output bit needs only the low column's lines. The three upper bits each use a 6x6 pattern of line pairs.

Top module: `dual_column_counter`

## Requirements
- R1: For every one of the 1024 input combinations, `total` equals the number of set bits in `lo_col` plus twice the number of set bits in `hi_col`.
- R2: When all ten input bits are set, `total` is 15 (4'b1111), the largest value.
- R3: Only the count of set bits in each column matters. Two inputs that have the same counts in both columns, with the bits in different positions, give the same `total`. Internally each column drives exactly one of its six count lines.
- R4: `total[0]` is 1 exactly when `lo_col` has an odd number of set bits. Changing `hi_col` never changes `total[0]`.
- R5: With all inputs clear, `total` is 0.
- R6: A single set bit in `hi_col`, with `lo_col` clear, gives `total` = 2, whatever its position.
- R7: The block holds no state. `total` follows its inputs within the same clock period, with no clock and no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_col | input | 5 | Column of weight-one bits |
| hi_col | input | 5 | Column of weight-two bits |
| total | output | 4 | Binary sum of the weighted columns |

## Verification
The internal checks assume that both inputs are fully driven two-state values once the surrounding logic has settled. A floating input would make the count-line check and the sum check meaningless. To stay within that assumption, the bench assigns both columns before any check. It then changes them only just after a rising edge and compares the output half a period later. The sweep covers the whole input space, so no assumption about which values can occur is needed.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int COL_H  = 5;
  localparam int HI_WT  = 2;
  localparam int LINES  = COL_H + 1;
  localparam int MAXSUM = COL_H + HI_WT * COL_H;
  localparam int OUT_W  = $clog2(MAXSUM + 1);
endpackage

// File: rtl/dcc_col_encoder.sv
module dcc_col_encoder #(
  parameter int COL_H = dcc_pkg::COL_H,
  localparam int LINES = COL_H + 1
) (
  input  logic [COL_H-1:0] col,
  output logic [LINES-1:0] line
);
  for (genvar gv = 0; gv < LINES; gv++) begin : g_line
    assign line[gv] = ($countones(col) == gv);
  end

  always_comb begin
    AST_ONE_LINE: assert ($countones(line) == 1) // R3
      else $error("count lines not one-hot");
  end
endmodule

// File: rtl/dcc_intersect.sv
module dcc_intersect #(
  parameter int LINES = dcc_pkg::LINES,
  parameter int HI_WT = dcc_pkg::HI_WT,
  parameter int OUT_W = dcc_pkg::OUT_W
) (
  input  logic [LINES-1:0] lo_line,
  input  logic [LINES-1:0] hi_line,
  output logic [OUT_W-1:0] sum
);
  // Bit 0: low column only, odd counts.
  logic [LINES-1:0] odd_hit;
  for (genvar ga = 0; ga < LINES; ga++) begin : g_odd
    if ((ga % 2) == 1) begin : g_on
      assign odd_hit[ga] = lo_line[ga];
    end else begin : g_off
      assign odd_hit[ga] = 1'b0;
    end
  end
  assign sum[0] = |odd_hit;

  // Upper bits: one line pair per matrix cell.
  for (genvar gi = 1; gi < OUT_W; gi++) begin : g_bit
    logic [LINES*LINES-1:0] hit;
    for (genvar ga = 0; ga < LINES; ga++) begin : g_row
      for (genvar gb = 0; gb < LINES; gb++) begin : g_cell
        localparam int CELL = ga + HI_WT * gb;
        if (((CELL >> gi) % 2) == 1) begin : g_on
          assign hit[ga*LINES+gb] = lo_line[ga] & hi_line[gb];
        end else begin : g_off
          assign hit[ga*LINES+gb] = 1'b0;
        end
      end
    end
    assign sum[gi] = |hit;
  end

  always_comb begin
    AST_ZERO_LINES: assert (!(lo_line[0] && hi_line[0]) || sum == '0) // R5
      else $error("zero counts gave nonzero sum");
  end
endmodule

// File: rtl/dual_column_counter.sv
module dual_column_counter
  import dcc_pkg::*;
(
  input  logic [COL_H-1:0] lo_col,
  input  logic [COL_H-1:0] hi_col,
  output logic [OUT_W-1:0] total
);
  logic [LINES-1:0] lo_line;
  logic [LINES-1:0] hi_line;

  dcc_col_encoder #(.COL_H(COL_H)) u_lo_enc (.col(lo_col), .line(lo_line));
  dcc_col_encoder #(.COL_H(COL_H)) u_hi_enc (.col(hi_col), .line(hi_line));

  dcc_intersect #(.LINES(LINES), .HI_WT(HI_WT), .OUT_W(OUT_W)) u_mat (
    .lo_line(lo_line),
    .hi_line(hi_line),
    .sum    (total)
  );

  always_comb begin
    AST_SUM_MATCH: assert (int'(total) == $countones(lo_col) + HI_WT * $countones(hi_col)) // R1
      else $error("sum mismatch");
    AST_LSB_PARITY: assert (total[0] == ^lo_col) // R4
      else $error("lsb not low-column parity");
  end
endmodule

// File: tb/dual_column_counter_test.sv
module dual_column_counter_test;
  logic       clk;
  logic       rst_n;
  logic [4:0] lo_col;
  logic [4:0] hi_col;
  logic [3:0] total;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  dual_column_counter uut (.lo_col(lo_col), .hi_col(hi_col), .total(total));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ones(input logic [4:0] v);
    int n = 0;
    for (int k = 0; k < 5; k++) n += int'(v[k]);
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (lo=%b hi=%b)", req, act, exp, lo_col, hi_col);
    end
  endtask

  task automatic apply(input logic [4:0] l, input logic [4:0] h);
    @(posedge clk);
    #1 lo_col = l; hi_col = h;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    lo_col = '0; hi_col = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5 / R7: zero in, zero out, no clocking needed
    @(negedge clk);
    check("R5", int'(total), 0);
    // R7: change between edges, observe before next edge
    #0.5 lo_col = 5'b00111;
    #0.5 check("R7", int'(total), 3);
    // R2
    apply(5'h1f, 5'h1f);
    check("R2", int'(total), 15);
    // R6
    for (int p = 0; p < 5; p++) begin
      apply(5'b0, 5'(1 << p));
      check("R6", int'(total), 2);
    end
    // R3: same counts, different positions
    apply(5'b00011, 5'b10100); check("R3", int'(total), 6);
    apply(5'b11000, 5'b00101); check("R3", int'(total), 6);
    apply(5'b01010, 5'b01001); check("R3", int'(total), 6);
    // R4: odd low column, sweep high column
    for (int h = 0; h < 32; h++) begin
      apply(5'b10101, 5'(h));
      check("R4", int'(total[0]), 1);
    end
    // R1 exhaustive, plus R4 parity on each
    for (int v = 0; v < 1024; v++) begin
      apply(v[4:0], v[9:5]);
      check("R1", int'(total), ones(v[4:0]) + 2 * ones(v[9:5]));
      check("R4", int'(total[0]), ones(v[4:0]) % 2);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule